// File: doc/BRIEF.md
# Multi-Mode Watchdog Timer with Power-of-Two Postscaler

The block is a watchdog timer that runs from a clock-enable strobe taken from a slow oscillator domain. A fixed prescaler divides the strobes into a base tick. A postscaler then stretches the base tick by a power of two chosen on a select input, so timeouts run from one base period up to 2^20 base periods.

A 2-bit mode input decides when the watchdog counts. It can count always, never, under a software enable bit, or only while the device is awake. Any of several system events clears both counters: a clear command, entry into sleep, a change of the oscillator-select value, a clock failure, or the block's own reset. When the count expires the block pulses a reset output if the device is awake, or a wake-up output if it is asleep. It also drives an output that asks for the slow clock source to run whenever counting is enabled.

Top module: `wdt_multi_mode`

## Requirements
- R1: `wdt_en_o` is high exactly when counting is enabled. The decode is on `mode_i`: 2'b11 always enabled; 2'b10 enabled only while `sleep_i` is low; 2'b01 enabled when `sw_en_i` is high; 2'b00 never enabled. `sw_en_i` has no effect in modes 2'b11 and 2'b00. While the block is disabled, no pulse is issued.
- R2: The count advances only in a cycle where `tick_en_i` is high and the block is enabled. Other cycles hold the count.
- R3: With `tap_sel_i` = n (n <= MAX_EXP), a timeout occurs on the PRE_DIV*2^n-th counted strobe after the last clear. PRE_DIV defaults to 128 and MAX_EXP to 20.
- R4: A `tap_sel_i` value above MAX_EXP behaves as MAX_EXP.
- R5: Any of the following clears the count in the cycle it occurs: `clr_cmd_i` high, a rising edge of `sleep_i`, `osc_sel_i` differing from its value in the previous cycle, or `clk_fail_i` high.
- R6: A clear in the same cycle as a would-be timeout wins: no pulse is issued and the count restarts from zero.
- R7: A timeout while `sleep_i` is low raises `rst_pulse_o` for exactly one cycle, in the cycle after the expiring strobe.
- R8: A timeout while `sleep_i` is high raises `wake_pulse_o` for one cycle, and `rst_pulse_o` stays low.
- R9: After a timeout the count restarts from zero, so the next timeout needs a full PRE_DIV*2^n further strobes.
- R10: While `rst_ni` is low, both pulse outputs are low and the count is zero. The previous sleep and oscillator-select values are taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| tick_en_i | input | 1 | Slow-oscillator strobe, one system cycle wide |
| mode_i | input | 2 | Enable mode select |
| sw_en_i | input | 1 | Software enable bit, used in mode 2'b01 |
| sleep_i | input | 1 | Device is in sleep |
| clr_cmd_i | input | 1 | Clear-watchdog command |
| osc_sel_i | input | OSC_W | Oscillator frequency select; any change clears |
| clk_fail_i | input | 1 | Clock failure detected |
| tap_sel_i | input | SEL_W | Postscaler exponent n, ratio 2^n |
| wdt_en_o | output | 1 | Request to run the slow clock source; high while enabled |
| rst_pulse_o | output | 1 | One-cycle device reset request |
| wake_pulse_o | output | 1 | One-cycle wake-up request |

## Verification
The assertions assume that `tap_sel_i` changes only in a cycle that also carries a clear. A new exponent below the current postscaler count would otherwise let the count run past its limit until it wraps. They also assume that the synchronous inputs are steady in each cycle. The stimulus sets a new exponent only together with `clr_cmd_i` and drives every input away from the active edge. Clear events, mode changes and sleep changes are kept rare, so timeouts still occur under every exponent used.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WDT_OFF   = 2'b00,
    WDT_SW    = 2'b01,
    WDT_AWAKE = 2'b10,
    WDT_ON    = 2'b11
  } wdt_mode_e;
endpackage

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
  import wdt_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  output logic       en_o
);
  wdt_mode_e mode;
  assign mode = wdt_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      WDT_ON:    en_o = 1'b1;
      WDT_AWAKE: en_o = ~sleep_i;
      WDT_SW:    en_o = sw_en_i;
      default:   en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  output logic base_tick_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign last        = (cnt_q == LAST);
  assign base_tick_o = step_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  a_r5_pre_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r2_pre_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int unsigned MAX_EXP = 20,
  parameter int unsigned SEL_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             timeout_o
);
  localparam int unsigned CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_EXP);

  logic [SEL_W-1:0] eff_sel;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  // saturate exponent
  assign eff_sel = (tap_sel_i > MAX_SEL) ? MAX_SEL : tap_sel_i;

  // mask = 2^eff - 1
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (eff_sel > SEL_W'(i));
  end

  assign last      = (cnt_q == mask);
  assign timeout_o = base_tick_i & last & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || timeout_o)   cnt_q <= '0;
    else if (base_tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  a_r9_post_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> (cnt_q == '0));
  a_r5_post_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r2_post_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!base_tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_multi_mode.sv
module wdt_multi_mode #(
  parameter int unsigned PRE_DIV = 128,
  parameter int unsigned MAX_EXP = 20,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned OSC_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic [1:0]       mode_i,
  input  logic             sw_en_i,
  input  logic             sleep_i,
  input  logic             clr_cmd_i,
  input  logic [OSC_W-1:0] osc_sel_i,
  input  logic             clk_fail_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             wdt_en_o,
  output logic             rst_pulse_o,
  output logic             wake_pulse_o
);
  logic             en;
  logic             step;
  logic             clr_any;
  logic             base_tick;
  logic             timeout;
  logic             sleep_q;
  logic [OSC_W-1:0] osc_q;

  wdt_mode_ctrl u_mode (
    .mode_i  (mode_i),
    .sw_en_i (sw_en_i),
    .sleep_i (sleep_i),
    .en_o    (en)
  );

  assign wdt_en_o = en;
  assign step     = en & tick_en_i;
  assign clr_any  = clr_cmd_i | clk_fail_i | (sleep_i & ~sleep_q) | (osc_sel_i != osc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      osc_q   <= '0;
    end else begin
      sleep_q <= sleep_i;
      osc_q   <= osc_sel_i;
    end
  end

  wdt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .clr_i       (clr_any),
    .base_tick_o (base_tick)
  );

  wdt_postscaler #(.MAX_EXP(MAX_EXP), .SEL_W(SEL_W)) u_post (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_tick_i (base_tick),
    .clr_i       (clr_any),
    .tap_sel_i   (tap_sel_i),
    .timeout_o   (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pulse_o  <= 1'b0;
      wake_pulse_o <= 1'b0;
    end else begin
      rst_pulse_o  <= timeout & ~sleep_i;
      wake_pulse_o <= timeout & sleep_i;
    end
  end

  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_o |=> !(rst_pulse_o || wake_pulse_o));
  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_any |=> !(rst_pulse_o || wake_pulse_o));
  a_r7_awake_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> !$past(sleep_i));
  a_r7_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o);
  a_r8_asleep_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> $past(sleep_i));
  a_r2_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_en_i && wdt_en_o) |=> !(rst_pulse_o || wake_pulse_o));
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !(rst_pulse_o || wake_pulse_o));
endmodule

// File: tb/tb_wdt_multi_mode.sv
module tb_wdt_multi_mode;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 8;
  localparam int MAXE = 6;
  localparam int SELW = 5;
  localparam int OSCW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sw = 1'b0, slp = 1'b0, clr = 1'b0, fail = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [OSCW-1:0] osc = '0;
  logic [SELW-1:0] tap = '0;
  logic en_o, rst_o, wake_o;

  int n_chk = 0, n_err = 0;
  int ref_cnt = 0;
  logic sleep_prev = 1'b0;
  logic [OSCW-1:0] osc_prev = '0;
  logic exp_rst = 1'b0, exp_wake = 1'b0;
  string tag = "R10";
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_multi_mode #(.PRE_DIV(PRE), .MAX_EXP(MAXE), .SEL_W(SELW), .OSC_W(OSCW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .mode_i(mode), .sw_en_i(sw),
    .sleep_i(slp), .clr_cmd_i(clr), .osc_sel_i(osc), .clk_fail_i(fail),
    .tap_sel_i(tap), .wdt_en_o(en_o), .rst_pulse_o(rst_o), .wake_pulse_o(wake_o)
  );

  function automatic logic model_en(logic [1:0] m, logic s, logic sl);
    case (m)
      2'b11: return 1'b1;
      2'b10: return ~sl;
      2'b01: return s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int model_limit(logic [SELW-1:0] t);
    int e = (int'(t) > MAXE) ? MAXE : int'(t);
    return PRE << e;
  endfunction

  task automatic check(string rq, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0b exp=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic check_int(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // one clock: model from current inputs, edge, compare at negedge
  task automatic cyc();
    logic c;
    c = clr | fail | (slp & ~sleep_prev) | (osc != osc_prev);
    exp_rst = 1'b0;
    exp_wake = 1'b0;
    if (c) ref_cnt = 0;
    else if (model_en(mode, sw, slp) && tick) begin
      if (ref_cnt + 1 == model_limit(tap)) begin
        ref_cnt = 0;
        if (slp) exp_wake = 1'b1; else exp_rst = 1'b1;
      end else ref_cnt++;
    end
    @(posedge clk);
    sleep_prev = slp;
    osc_prev = osc;
    @(negedge clk);
    if (rst_o || wake_o) pulses++;
    check({tag, " R7 reset pulse"}, rst_o, exp_rst);
    check({tag, " R8 wake pulse"}, wake_o, exp_wake);
    check({tag, " R1 enable"}, en_o, model_en(mode, sw, slp));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_tap(int n);
    tap = SELW'(n);
    clr = 1'b1;
    cyc();
    clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 rst low", rst_o, 1'b0);
    check("R10 wake low", wake_o, 1'b0);
    rst_n = 1'b1;

    // R3 R7 R9: always on, tap 0, two back-to-back timeouts
    tag = "R3 R9";
    mode = 2'b11; tick = 1'b1;
    set_tap(0);
    pulses = 0;
    run(2 * PRE);
    check_int("R9 two timeouts in 2*limit", pulses, 2);

    // R2 R3: tap 2, gapped strobes
    tag = "R2 R3";
    set_tap(2);
    for (int i = 0; i < 200; i++) begin tick = i[0] | i[2]; cyc(); end
    tick = 1'b1;

    // R4 saturation
    tag = "R4";
    set_tap(31);
    pulses = 0;
    run(model_limit(SELW'(MAXE)) - 1);
    check_int("R4 no pulse before saturated limit", pulses, 0);
    run(1);
    check_int("R4 pulse at saturated limit", pulses, 1);

    // R5 R6: each clear source on the timeout cycle
    tag = "R5 R6";
    set_tap(1);
    run(2 * PRE - 1); clr = 1'b1; cyc(); clr = 1'b0;
    run(2 * PRE - 1); fail = 1'b1; cyc(); fail = 1'b0;
    run(2 * PRE - 1); osc = osc + 1'b1; cyc();
    run(2 * PRE - 1); slp = 1'b1; cyc();
    // R8 asleep in always mode
    tag = "R8";
    pulses = 0;
    run(2 * PRE);
    check_int("R8 wake after limit asleep", pulses, 1);
    // R1 awake-only mode while asleep
    tag = "R1 awake-only";
    mode = 2'b10; run(40);
    slp = 1'b0; run(3 * PRE);
    // R1 software mode
    tag = "R1 sw";
    mode = 2'b01; sw = 1'b0; run(40);
    sw = 1'b1; run(3 * PRE);
    // R1 disabled, sw ignored
    tag = "R1 off";
    mode = 2'b00; run(3 * PRE);
    mode = 2'b11; sw = 1'b0; run(3 * PRE);

    // random mix
    tag = "R2 R5 random";
    for (int i = 0; i < 40000; i++) begin
      tick = ($urandom % 8) != 0;
      clr  = ($urandom % 3000) == 0;
      fail = ($urandom % 5000) == 0;
      if (($urandom % 4000) == 0) osc = OSCW'($urandom);
      if (($urandom % 2000) == 0) slp = ~slp;
      if (($urandom % 1500) == 0) sw = ~sw;
      if (($urandom % 5000) == 0) mode = 2'($urandom);
      if (($urandom % 6000) == 0) begin tap = SELW'($urandom % 3); clr = 1'b1; end
      cyc();
    end
    clr = 1'b0; fail = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule